// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Sequencer

This block carries out the control-state updates that a machine-only processor core performs when it takes a synchronous exception or an interrupt, and when it runs the trap-return instruction. On entry it produces the saved return address, the recorded cause word, the trap value and the new interrupt-enable bits, together with the handler address. The handler address comes from the trap-vector register in one of three forms: a single base, a base plus a per-cause offset, or a word fetched from a handler table. On return it restores the interrupt enable from its saved copy and redirects the program counter to the saved return address.

The core presents a 32-bit trap descriptor (active flag, cause code, trap kind), the current and next program counters, the faulting value and latched fault address, and the current values of the relevant control registers. The block answers with registered one-cycle write strobes and data for the core's register file and program counter. For table mode it issues one read on a simple synchronous memory port, and the memory returns data and an error flag one cycle later.

Top module: `mtrap_seq`

## Requirements
- R1: After reset every write strobe (`trap_we_o`, `tval_we_o`, `stat_we_o`, `pc_we_o`, `pend_clr_o`) and `tbl_req_o` is low.
- R2: A trap is taken only when `enter_i` is high and descriptor bit 31 is 1. With bit 31 at 0 the request has no effect: no strobe rises in the following cycle. A nonzero trap-kind field (bits 15:0) marks an interrupt, and zero marks an exception.
- R3: Outside table mode, all updates of a trap appear as a one-cycle pulse in the cycle after the request. For an exception, `epc_o` = `cur_pc_i` and `pend_clr_o` = 0. For an interrupt, `epc_o` = `next_pc_i` and `pend_clr_o` = 1. `cause_o` carries the interrupt flag in its top bit and the 15-bit cause (bits 30:16) in its low bits. The environment-call code 11 is recorded as 8 plus machine privilege 3.
- R4: For an exception, `tval_o` is `fault_val_i` for cause 0, `cur_pc_i` for cause 3, `fault_addr_i` for causes 4 and 6, and zero for every other cause except 2. An interrupt raises no `tval_we_o`.
- R5: For cause 2, if `rvc_en_i` is 1 and `fault_val_i[1:0]` is not 2'b11, `tval_o` keeps only the low 16 bits of `fault_val_i`. Otherwise `tval_o` is the full value.
- R6: On trap entry `ie_o` = 0, `pie_o` = `ie_i` and `pp_o` = 2'b11.
- R7: The vector mode is `tvec_i[1:0]`. An exception always jumps to `tvec_i` with bits 1:0 cleared. An interrupt with mode 2'b01 jumps to that base plus 4 times the cause. An interrupt with mode 2'b00 or 2'b10 jumps to the base.
- R8: An interrupt with mode 2'b11 raises `tbl_req_o` for one cycle, in the cycle after the request, with `tbl_addr_o` = `tbl_ptr_i`. The data is sampled one cycle later. All updates for this trap then pulse two cycles later than in R3, with `pc_o` = `tbl_data_i`.
- R9: If `tbl_err_i` is 1 with the table data, `pc_o` is the captured `cur_pc_i`. The other trap updates still happen.
- R10: A return request (`ret_i` with no trap taken) pulses, in the next cycle, `stat_we_o` with `ie_o` = `pie_i`, `pie_o` = 1 and `pp_o` = 2'b11, and `pc_we_o` with `pc_o` = `epc_i`. It raises no `trap_we_o` or `tval_we_o`.
- R11: A trap and a return requested in the same cycle: the trap is taken and the return is dropped.
- R12: Trap or return requests that arrive while a table read is in flight are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_i | input | 1 | Trap request |
| ret_i | input | 1 | Trap-return request |
| flags_i | input | 32 | Trap descriptor: active, cause, kind |
| cur_pc_i | input | XLEN | Address of the trapping instruction |
| next_pc_i | input | XLEN | Address of the next instruction |
| fault_val_i | input | XLEN | Faulting value or instruction bits |
| fault_addr_i | input | XLEN | Latched fault address |
| rvc_en_i | input | 1 | Compressed instructions enabled |
| tvec_i | input | XLEN | Trap-vector register (base and mode) |
| tbl_ptr_i | input | XLEN | Handler table pointer |
| ie_i | input | 1 | Current global interrupt enable |
| pie_i | input | 1 | Current saved interrupt enable |
| epc_i | input | XLEN | Current saved return address |
| tbl_data_i | input | XLEN | Table read data |
| tbl_err_i | input | 1 | Table read error |
| tbl_req_o | output | 1 | Table read request |
| tbl_addr_o | output | XLEN | Table read address |
| trap_we_o | output | 1 | Write strobe for return address and cause |
| epc_o | output | XLEN | New saved return address |
| cause_o | output | XLEN | New cause word |
| tval_we_o | output | 1 | Trap value write strobe |
| tval_o | output | XLEN | New trap value |
| stat_we_o | output | 1 | Status write strobe |
| ie_o | output | 1 | New interrupt enable |
| pie_o | output | 1 | New saved interrupt enable |
| pp_o | output | 2 | New previous privilege |
| pend_clr_o | output | 1 | Clear pending interrupt |
| pc_we_o | output | 1 | Program counter redirect strobe |
| pc_o | output | XLEN | Redirect target |

## Verification
The bench aims at the cause-2 width rule with both low-bit patterns. A design that ignores it reports the upper half of a compressed instruction, or truncates a full one. It separates exceptions from interrupts under vectored mode: a design that offsets exceptions jumps past the common handler. The table path is run both with an error and with a return request injected during the fetch. A design with the wrong latency, a lost error or no request filter shows the wrong target, an early strobe, or a late return pulse. The bench also sends an inactive descriptor and a trap together with a return: a design that honors the inactive request, or lets the return win the tie, writes status with the wrong enables.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TREQ  = 2'd1,
    ST_TWAIT = 2'd2
  } seq_state_e;

  localparam int unsigned FLAG_ACT_BIT = 31;
  localparam int unsigned CAUSE_LSB    = 16;
  localparam int unsigned CAUSE_W      = 15;
  localparam int unsigned KIND_W       = 16;

  localparam logic [1:0] VEC_SPREAD = 2'b01;
  localparam logic [1:0] VEC_TABLE  = 2'b11;
  localparam logic [1:0] PRIV_MACH  = 2'b11;

  localparam logic [CAUSE_W-1:0] EXC_INSN_MISALIGN = 15'd0;
  localparam logic [CAUSE_W-1:0] EXC_ILLEGAL       = 15'd2;
  localparam logic [CAUSE_W-1:0] EXC_BREAK         = 15'd3;
  localparam logic [CAUSE_W-1:0] EXC_LOAD_MISALIGN = 15'd4;
  localparam logic [CAUSE_W-1:0] EXC_STORE_MISALIGN= 15'd6;
  localparam logic [CAUSE_W-1:0] EXC_ENV_CALL      = 15'd11;
  localparam logic [CAUSE_W-1:0] ENV_CALL_BASE     = 15'd8;
endpackage

// File: rtl/mtrap_decode.sv
module mtrap_decode
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]        flags,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [XLEN-1:0]    fault_val,
  input  logic [XLEN-1:0]    fault_addr,
  input  logic               rvc_en,
  output logic               active,
  output logic               is_irq,
  output logic [CAUSE_W-1:0] code,
  output logic [XLEN-1:0]    cause_word,
  output logic               tval_we,
  output logic [XLEN-1:0]    tval
);
  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  logic [CAUSE_W-1:0] raw_code;

  assign active   = flags[FLAG_ACT_BIT];
  assign raw_code = flags[CAUSE_LSB +: CAUSE_W];
  assign is_irq   = |flags[KIND_W-1:0];

  always_comb begin
    code = raw_code;
    if (!is_irq && raw_code == EXC_ENV_CALL)
      code = ENV_CALL_BASE + CAUSE_W'(PRIV_MACH);
  end

  assign cause_word = {is_irq, {PAD_W{1'b0}}, code};

  always_comb begin
    tval_we = !is_irq;
    tval    = '0;
    if (!is_irq) begin
      unique case (code)
        EXC_INSN_MISALIGN: tval = fault_val;
        EXC_ILLEGAL: begin
          if (rvc_en && fault_val[1:0] != 2'b11)
            tval = {{(XLEN-16){1'b0}}, fault_val[15:0]};
          else
            tval = fault_val;
        end
        EXC_BREAK:          tval = cur_pc;
        EXC_LOAD_MISALIGN,
        EXC_STORE_MISALIGN: tval = fault_addr;
        default:            tval = '0;
      endcase
    end
  end
endmodule

// File: rtl/mtrap_target.sv
module mtrap_target
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]    tvec,
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] code,
  output logic               use_table,
  output logic [XLEN-1:0]    target
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign base      = {tvec[XLEN-1:2], 2'b00};
  assign offset    = XLEN'({code, 2'b00});
  assign use_table = is_irq && tvec[1:0] == VEC_TABLE;

  always_comb begin
    if (is_irq && tvec[1:0] == VEC_SPREAD) target = base + offset;
    else                                   target = base;
  end
endmodule

// File: rtl/mtrap_seq.sv
module mtrap_seq
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enter_i,
  input  logic            ret_i,
  input  logic [31:0]     flags_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic [XLEN-1:0] next_pc_i,
  input  logic [XLEN-1:0] fault_val_i,
  input  logic [XLEN-1:0] fault_addr_i,
  input  logic            rvc_en_i,
  input  logic [XLEN-1:0] tvec_i,
  input  logic [XLEN-1:0] tbl_ptr_i,
  input  logic            ie_i,
  input  logic            pie_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] tbl_data_i,
  input  logic            tbl_err_i,
  output logic            tbl_req_o,
  output logic [XLEN-1:0] tbl_addr_o,
  output logic            trap_we_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] cause_o,
  output logic            tval_we_o,
  output logic [XLEN-1:0] tval_o,
  output logic            stat_we_o,
  output logic            ie_o,
  output logic            pie_o,
  output logic [1:0]      pp_o,
  output logic            pend_clr_o,
  output logic            pc_we_o,
  output logic [XLEN-1:0] pc_o
);
  seq_state_e state_q;

  logic               dec_active, dec_irq, dec_tval_we, tgt_table;
  logic [CAUSE_W-1:0] dec_code;
  logic [XLEN-1:0]    dec_cause, dec_tval, tgt_pc;
  logic               take_trap, take_ret;

  // captured trap for the table path
  logic               hold_irq, hold_tval_we, hold_pie;
  logic [XLEN-1:0]    hold_epc, hold_cause, hold_tval, hold_pc;

  mtrap_decode #(.XLEN(XLEN)) u_dec (
    .flags      (flags_i),
    .cur_pc     (cur_pc_i),
    .fault_val  (fault_val_i),
    .fault_addr (fault_addr_i),
    .rvc_en     (rvc_en_i),
    .active     (dec_active),
    .is_irq     (dec_irq),
    .code       (dec_code),
    .cause_word (dec_cause),
    .tval_we    (dec_tval_we),
    .tval       (dec_tval)
  );

  mtrap_target #(.XLEN(XLEN)) u_tgt (
    .tvec      (tvec_i),
    .is_irq    (dec_irq),
    .code      (dec_code),
    .use_table (tgt_table),
    .target    (tgt_pc)
  );

  assign take_trap = state_q == ST_IDLE && enter_i && dec_active;
  assign take_ret  = state_q == ST_IDLE && ret_i && !take_trap;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      tbl_req_o    <= 1'b0;
      tbl_addr_o   <= '0;
      trap_we_o    <= 1'b0;
      epc_o        <= '0;
      cause_o      <= '0;
      tval_we_o    <= 1'b0;
      tval_o       <= '0;
      stat_we_o    <= 1'b0;
      ie_o         <= 1'b0;
      pie_o        <= 1'b0;
      pp_o         <= PRIV_MACH;
      pend_clr_o   <= 1'b0;
      pc_we_o      <= 1'b0;
      pc_o         <= '0;
      hold_irq     <= 1'b0;
      hold_tval_we <= 1'b0;
      hold_pie     <= 1'b0;
      hold_epc     <= '0;
      hold_cause   <= '0;
      hold_tval    <= '0;
      hold_pc      <= '0;
    end else begin
      tbl_req_o  <= 1'b0;
      trap_we_o  <= 1'b0;
      tval_we_o  <= 1'b0;
      stat_we_o  <= 1'b0;
      pend_clr_o <= 1'b0;
      pc_we_o    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_trap && tgt_table) begin
            tbl_req_o    <= 1'b1;
            tbl_addr_o   <= tbl_ptr_i;
            hold_irq     <= dec_irq;
            hold_tval_we <= dec_tval_we;
            hold_pie     <= ie_i;
            hold_epc     <= next_pc_i;
            hold_cause   <= dec_cause;
            hold_tval    <= dec_tval;
            hold_pc      <= cur_pc_i;
            state_q      <= ST_TREQ;
          end else if (take_trap) begin
            trap_we_o  <= 1'b1;
            epc_o      <= dec_irq ? next_pc_i : cur_pc_i;
            cause_o    <= dec_cause;
            tval_we_o  <= dec_tval_we;
            if (dec_tval_we) tval_o <= dec_tval;
            stat_we_o  <= 1'b1;
            ie_o       <= 1'b0;
            pie_o      <= ie_i;
            pp_o       <= PRIV_MACH;
            pend_clr_o <= dec_irq;
            pc_we_o    <= 1'b1;
            pc_o       <= tgt_pc;
          end else if (take_ret) begin
            stat_we_o <= 1'b1;
            ie_o      <= pie_i;
            pie_o     <= 1'b1;
            pp_o      <= PRIV_MACH;
            pc_we_o   <= 1'b1;
            pc_o      <= epc_i;
          end
        end
        ST_TREQ: state_q <= ST_TWAIT;
        ST_TWAIT: begin
          trap_we_o  <= 1'b1;
          epc_o      <= hold_epc;
          cause_o    <= hold_cause;
          tval_we_o  <= hold_tval_we;
          if (hold_tval_we) tval_o <= hold_tval;
          stat_we_o  <= 1'b1;
          ie_o       <= 1'b0;
          pie_o      <= hold_pie;
          pp_o       <= PRIV_MACH;
          pend_clr_o <= hold_irq;
          pc_we_o    <= 1'b1;
          pc_o       <= tbl_err_i ? hold_pc : tbl_data_i;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: an inactive descriptor leaves every output strobe low
  p_inactive_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && enter_i && !flags_i[FLAG_ACT_BIT] && !ret_i)
      |=> !(trap_we_o || stat_we_o || pc_we_o || tbl_req_o));

  // R3: pending clear only for interrupts, always with the trap write
  p_pend_clr_irq_r3: assert property (@(posedge clk) disable iff (rst)
    pend_clr_o |-> trap_we_o && cause_o[XLEN-1]);

  // R4: trap value only written for exceptions
  p_tval_exc_only_r4: assert property (@(posedge clk) disable iff (rst)
    tval_we_o |-> trap_we_o && !cause_o[XLEN-1]);

  // R6: every trap write disables interrupts and records machine mode
  p_entry_status_r6: assert property (@(posedge clk) disable iff (rst)
    trap_we_o |-> stat_we_o && !ie_o && pp_o == PRIV_MACH && pc_we_o);

  // R8: table request is followed by one quiet cycle, then the update
  p_tbl_latency_r8: assert property (@(posedge clk) disable iff (rst)
    tbl_req_o |=> !pc_we_o ##1 (pc_we_o && trap_we_o));

  // R10: return restores enables and jumps to the saved address
  p_ret_restore_r10: assert property (@(posedge clk) disable iff (rst)
    take_ret |=> pc_we_o && stat_we_o && !trap_we_o && pie_o
                 && pc_o == $past(epc_i) && ie_o == $past(pie_i));

  // R12: no second table request while one is in flight
  p_tbl_single_r12: assert property (@(posedge clk) disable iff (rst)
    tbl_req_o |=> !tbl_req_o);
endmodule

// File: tb/sim_mtrap_seq.sv
`timescale 1ns/1ps
module sim_mtrap_seq;
  localparam int XLEN = 32;
  localparam int MAX_CYC = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            enter_i = 0, ret_i = 0, rvc_en_i = 0, ie_i = 0, pie_i = 0;
  logic [31:0]     flags_i = '0;
  logic [XLEN-1:0] cur_pc_i = '0, next_pc_i = '0, fault_val_i = '0, fault_addr_i = '0;
  logic [XLEN-1:0] tvec_i = '0, tbl_ptr_i = '0, epc_i = '0;
  logic [XLEN-1:0] tbl_data_i = '0;
  logic            tbl_err_i = 0;
  logic            tbl_req_o, trap_we_o, tval_we_o, stat_we_o, ie_o, pie_o, pend_clr_o, pc_we_o;
  logic [XLEN-1:0] tbl_addr_o, epc_o, cause_o, tval_o, pc_o;
  logic [1:0]      pp_o;

  mtrap_seq #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst(rst), .enter_i(enter_i), .ret_i(ret_i), .flags_i(flags_i),
    .cur_pc_i(cur_pc_i), .next_pc_i(next_pc_i), .fault_val_i(fault_val_i),
    .fault_addr_i(fault_addr_i), .rvc_en_i(rvc_en_i), .tvec_i(tvec_i),
    .tbl_ptr_i(tbl_ptr_i), .ie_i(ie_i), .pie_i(pie_i), .epc_i(epc_i),
    .tbl_data_i(tbl_data_i), .tbl_err_i(tbl_err_i), .tbl_req_o(tbl_req_o),
    .tbl_addr_o(tbl_addr_o), .trap_we_o(trap_we_o), .epc_o(epc_o),
    .cause_o(cause_o), .tval_we_o(tval_we_o), .tval_o(tval_o),
    .stat_we_o(stat_we_o), .ie_o(ie_o), .pie_o(pie_o), .pp_o(pp_o),
    .pend_clr_o(pend_clr_o), .pc_we_o(pc_we_o), .pc_o(pc_o)
  );

  // handler table model: one-cycle read, error above 64 bytes
  function automatic logic [XLEN-1:0] tbl_word(input logic [XLEN-1:0] a);
    return 32'h4000_0000 | (a << 4);
  endfunction

  always_ff @(posedge clk) begin
    if (tbl_req_o) begin
      tbl_data_i <= tbl_word(tbl_addr_o);
      tbl_err_i  <= tbl_addr_o >= 32'd64;
    end
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] f_tval(input logic [14:0] c, input logic [XLEN-1:0] fv,
      input logic [XLEN-1:0] fa, input logic [XLEN-1:0] pc, input logic rvc);
    if (c == 0) return fv;
    if (c == 2) return (rvc && fv[1:0] != 2'b11) ? (fv & 32'h0000_ffff) : fv;
    if (c == 3) return pc;
    if (c == 4 || c == 6) return fa;
    return '0;
  endfunction

  function automatic logic [XLEN-1:0] f_target(input logic [XLEN-1:0] tv, input logic irq,
      input logic [14:0] c);
    logic [XLEN-1:0] b = tv & ~32'h3;
    if (irq && tv[1:0] == 2'b01) return b + 4 * XLEN'(c);
    return b;
  endfunction

  task automatic do_trap(input bit with_ret, input bit ret_in_wait);
    logic irq = |flags_i[15:0];
    logic [14:0] c = flags_i[30:16];
    bit tbl = irq && tvec_i[1:0] == 2'b11;
    logic [XLEN-1:0] exp_pc;
    enter_i = 1;
    ret_i = with_ret;
    @(posedge clk);
    @(negedge clk);
    enter_i = 0;
    ret_i = 0;
    if (tbl) begin
      chk("R8 table request", XLEN'(tbl_req_o), 1);
      chk("R8 table address", tbl_addr_o, tbl_ptr_i);
      chk("R8 no early update", XLEN'(pc_we_o), 0);
      if (ret_in_wait) ret_i = 1;
      @(negedge clk);
      ret_i = 0;
      chk("R8 no update during read", XLEN'(pc_we_o | stat_we_o), 0);
      @(negedge clk);
      exp_pc = (tbl_ptr_i >= 64) ? cur_pc_i : tbl_word(tbl_ptr_i);
      chk(tbl_ptr_i >= 64 ? "R9 error keeps pc" : "R8 table target", pc_o, exp_pc);
    end else begin
      chk("R7 target", pc_o, f_target(tvec_i, irq, c));
    end
    chk("R3 trap strobe", XLEN'(trap_we_o), 1);
    chk("R3 saved address", epc_o, irq ? next_pc_i : cur_pc_i);
    chk("R3 cause word", cause_o, {irq, 16'd0, c});
    chk("R3 pending clear", XLEN'(pend_clr_o), XLEN'(irq));
    chk("R4 tval strobe", XLEN'(tval_we_o), XLEN'(!irq));
    if (!irq) chk("R4/R5 tval", tval_o, f_tval(c, fault_val_i, fault_addr_i, cur_pc_i, rvc_en_i));
    chk("R6 status", {29'd0, ie_o, pie_o, pp_o == 2'b11}, {29'd0, 1'b0, ie_i, 1'b1});
    chk("R6 pc strobe", XLEN'(pc_we_o & stat_we_o), 1);
    if (tbl && ret_in_wait) begin
      @(negedge clk);
      chk("R12 dropped return", XLEN'(pc_we_o | stat_we_o), 0);
    end
  endtask

  task automatic set_trap(input logic irq, input logic [14:0] c);
    flags_i = {1'b1, c, irq ? 16'd1 : 16'd0};
    cur_pc_i = $urandom & ~32'h1;
    next_pc_i = cur_pc_i + 4;
    fault_val_i = $urandom;
    fault_addr_i = $urandom;
    ie_i = $urandom;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 strobes after reset",
        XLEN'({trap_we_o, tval_we_o, stat_we_o, pc_we_o, pend_clr_o, tbl_req_o}), 0);

    // R2: inactive descriptor
    set_trap(1'b0, 15'd2);
    flags_i[31] = 1'b0;
    enter_i = 1;
    @(posedge clk); @(negedge clk);
    enter_i = 0;
    chk("R2 inactive ignored", XLEN'({trap_we_o, stat_we_o, pc_we_o, tbl_req_o}), 0);

    // R3: environment call
    tvec_i = 32'h0000_1001;
    set_trap(1'b0, 15'd11); do_trap(0, 0);
    chk("R3 env call code", cause_o, 32'd11);

    // R5: compressed illegal instruction, both low-bit forms
    rvc_en_i = 1;
    set_trap(1'b0, 15'd2); fault_val_i = 32'hABCD_1232; do_trap(0, 0);
    chk("R5 truncated", tval_o, 32'h0000_1232);
    set_trap(1'b0, 15'd2); fault_val_i = 32'hABCD_1233; do_trap(0, 0);
    chk("R5 full", tval_o, 32'hABCD_1233);
    rvc_en_i = 0;
    set_trap(1'b0, 15'd2); fault_val_i = 32'hABCD_1232; do_trap(0, 0);

    // R7: vectored interrupt vs exception, mode 2 interrupt
    tvec_i = 32'h0000_2001;
    set_trap(1'b1, 15'd7); do_trap(0, 0);
    chk("R7 spread", pc_o, 32'h0000_201C);
    set_trap(1'b0, 15'd7); do_trap(0, 0);
    tvec_i = 32'h0000_2002;
    set_trap(1'b1, 15'd7); do_trap(0, 0);

    // R8/R9/R12: table mode
    tvec_i = 32'h0000_3003;
    tbl_ptr_i = 32'd16; set_trap(1'b1, 15'd11); do_trap(0, 0);
    tbl_ptr_i = 32'd128; set_trap(1'b1, 15'd3); do_trap(0, 0);
    tbl_ptr_i = 32'd8; set_trap(1'b1, 15'd5); pie_i = 1; do_trap(0, 1);

    // R10: return
    for (int i = 0; i < 4; i++) begin
      epc_i = $urandom; pie_i = i[0];
      ret_i = 1;
      @(posedge clk); @(negedge clk);
      ret_i = 0;
      chk("R10 return pc", pc_o, epc_i);
      chk("R10 return status", {28'd0, pc_we_o, stat_we_o, ie_o, pie_o}, {28'd0, 1'b1, 1'b1, pie_i, 1'b1});
      chk("R10 no trap write", XLEN'(trap_we_o | tval_we_o), 0);
      chk("R10 pp", XLEN'(pp_o), 3);
    end

    // R11: trap and return together
    tvec_i = 32'h0000_4000; pie_i = 1;
    set_trap(1'b0, 15'd4); ie_i = 1; do_trap(1, 0);
    chk("R11 trap wins", XLEN'(ie_o), 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [14:0] c = ($urandom % 4 == 0) ? 15'($urandom) : 15'($urandom % 16);
      tvec_i = $urandom;
      tbl_ptr_i = $urandom % 96;
      rvc_en_i = $urandom;
      set_trap(1'($urandom), c);
      do_trap(($urandom % 5) == 0, ($urandom % 5) == 0);
      @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule